// File: doc/BRIEF.md
# Chained NFA String Matcher

The block searches a byte stream for a fixed set of exact strings. It accepts one payload character per clock, marked by a valid strobe. It compares that character against every stored pattern character at the same time. Each stored character is one state of an automaton in which common prefixes are merged. Each non-start state has exactly one predecessor state. A state fires when the current character equals its own character and its predecessor fired on the previous accepted byte. A start state needs no predecessor, so it may fire on any byte. A one-bit register per state carries that result forward. No transition table is read after the compare.

Each pattern has an output flag. The flag is taken from the state that holds the pattern's last character, so it rises in the same cycle as the final matching byte arrives. A packet-start strobe stops partial matches from crossing a packet boundary.

The stored characters, start flags, predecessor links and per-pattern final states come from parameterised defaults, which hold the set CF, BCD, BBA, BA, EBBC, EBC. Reset restores those defaults, and a small write port can overwrite any of them.

Top module: `str_match_top`

## Requirements
- R1: Synchronous active-high reset clears every state register, so no character after reset can continue a chain begun before it.
- R2: A state with its start flag set may fire on any accepted byte, including the first byte of a packet.
- R3: A pattern output is high in the same cycle as the valid byte that completes the pattern, and only in that cycle.
- R4: If any accepted byte inside the pattern does not match, the pattern output does not fire.
- R5: While the valid strobe is low, every pattern output is low and all state registers keep their values. A pattern may span a gap in validity.
- R6: A packet-start strobe discards all earlier state. If a valid byte comes with the strobe, that byte is judged as the first byte of a new packet: only start states may fire on it.
- R7: One state may be the predecessor of several states. Several pattern outputs may fire on the same byte, including one pattern that ends inside another.
- R8: A write with select 0 stores a character, start flag and predecessor index into the state at the given address. The write takes effect from the next cycle.
- R9: A write with select 1 sets which state drives the pattern output at the given address (the predecessor field carries the state index). The write takes effect from the next cycle.
- R10: Default pattern order on the output bits, from bit 0 to bit 5: CF, BCD, BBA, BA, EBBC, EBC. Reset restores this set after any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input character is valid this cycle |
| in_char | input | 8 | Payload character |
| pkt_start | input | 1 | First byte of a new packet or a packet boundary |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = state entry write, 1 = pattern final-state write |
| cfg_addr | input | 6 | State index, or pattern index |
| cfg_char | input | 8 | Character for a state write |
| cfg_root | input | 1 | Start flag for a state write |
| cfg_parent | input | 6 | Predecessor index, or final-state index for a pattern write |
| match_o | output | 6 | One match flag per pattern |

## Verification
The packet-start strobe and a valid byte can come in the same cycle. The design must then clear the old chain and still judge that byte against the start states. The bench provokes this in three ways. It sends a pattern's first character, then its second character with the strobe. It sends a non-start character with the strobe. It begins a pattern on a strobed byte. The first two must give no flag and the third must give a flag. A random run also raises the strobe on valid and idle cycles. That run is judged against a software substring search that resets its history at each strobe.

// File: rtl/smt_pkg.sv
package smt_pkg;

    localparam int CHAR_W  = 8;
    localparam int MAX_ENT = 64;
    localparam int IDX_W   = $clog2(MAX_ENT);
    localparam int DEF_ENT = 13;
    localparam int DEF_PAT = 6;

    typedef struct packed {
        logic [CHAR_W-1:0] ch;
        logic              root;
        logic [IDX_W-1:0]  parent;
    } entry_cfg_t;

    typedef enum logic {
        CFG_ENTRY = 1'b0,
        CFG_TAIL  = 1'b1
    } cfg_kind_e;

    function automatic entry_cfg_t mk_entry(logic [CHAR_W-1:0] c, logic r, int par);
        entry_cfg_t e;
        e.ch     = c;
        e.root   = r;
        e.parent = IDX_W'(par);
        return e;
    endfunction

    // Merged automaton: C-F | B-(C-D | B-A | A) | E-B-(B-C | C)
    function automatic entry_cfg_t def_entry(int i);
        case (i)
            0:       return mk_entry("C", 1'b1, 0);
            1:       return mk_entry("F", 1'b0, 0);
            2:       return mk_entry("B", 1'b1, 0);
            3:       return mk_entry("C", 1'b0, 2);
            4:       return mk_entry("D", 1'b0, 3);
            5:       return mk_entry("B", 1'b0, 2);
            6:       return mk_entry("A", 1'b0, 5);
            7:       return mk_entry("A", 1'b0, 2);
            8:       return mk_entry("E", 1'b1, 0);
            9:       return mk_entry("B", 1'b0, 8);
            10:      return mk_entry("B", 1'b0, 9);
            11:      return mk_entry("C", 1'b0, 10);
            12:      return mk_entry("C", 1'b0, 9);
            default: return mk_entry(8'h00, 1'b0, 0);
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] def_tail(int p);
        case (p)
            0:       return IDX_W'(1);
            1:       return IDX_W'(4);
            2:       return IDX_W'(6);
            3:       return IDX_W'(7);
            4:       return IDX_W'(11);
            5:       return IDX_W'(12);
            default: return IDX_W'(MAX_ENT - 1);
        endcase
    endfunction

endpackage

// File: rtl/smt_cfg_store.sv
module smt_cfg_store
    import smt_pkg::*;
#(
    parameter int N_ENT = DEF_ENT,
    parameter int N_PAT = DEF_PAT
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  cfg_kind_e                         cfg_kind,
    input  logic [IDX_W-1:0]                  cfg_addr,
    input  logic [CHAR_W-1:0]                 cfg_char,
    input  logic                              cfg_root,
    input  logic [IDX_W-1:0]                  cfg_parent,
    output entry_cfg_t [N_ENT-1:0]            ent_o,
    output logic [N_PAT-1:0][IDX_W-1:0]       tail_o
);

    entry_cfg_t [N_ENT-1:0]      ent_q;
    logic [N_PAT-1:0][IDX_W-1:0] tail_q;

    generate
        for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q[gi] <= def_entry(gi);
                end else if (cfg_we && cfg_kind == CFG_ENTRY && cfg_addr == IDX_W'(gi)) begin
                    ent_q[gi] <= '{ch: cfg_char, root: cfg_root, parent: cfg_parent};
                end
            end
        end

        for (genvar gp = 0; gp < N_PAT; gp++) begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) begin
                    tail_q[gp] <= def_tail(gp);
                end else if (cfg_we && cfg_kind == CFG_TAIL && cfg_addr == IDX_W'(gp)) begin
                    tail_q[gp] <= cfg_parent;
                end
            end
        end
    endgenerate

    assign ent_o  = ent_q;
    assign tail_o = tail_q;

endmodule

// File: rtl/smt_entry.sv
module smt_entry
    import smt_pkg::*;
(
    input  entry_cfg_t          cfg,
    input  logic                in_valid,
    input  logic [CHAR_W-1:0]   in_char,
    input  logic [MAX_ENT-1:0]  prev_pad,
    output logic                hit
);

    logic char_eq;
    logic enabled;

    always_comb begin
        char_eq = (in_char == cfg.ch);
        // A start state is always enabled; others follow their single predecessor.
        enabled = cfg.root | prev_pad[cfg.parent];
        hit     = in_valid & char_eq & enabled;
    end

endmodule

// File: rtl/smt_chain_reg.sv
module smt_chain_reg #(
    parameter int N_ENT = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              pkt_start,
    input  logic [N_ENT-1:0]  hit,
    output logic [N_ENT-1:0]  chain_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else if (in_valid) begin
            chain_q <= hit;
        end else if (pkt_start) begin
            chain_q <= '0;
        end
    end

endmodule

// File: rtl/smt_tail_sel.sv
module smt_tail_sel
    import smt_pkg::*;
#(
    parameter int N_PAT = DEF_PAT
) (
    input  logic [MAX_ENT-1:0]           hit_pad,
    input  logic [N_PAT-1:0][IDX_W-1:0]  tail,
    output logic [N_PAT-1:0]             match_o
);

    generate
        for (genvar gp = 0; gp < N_PAT; gp++) begin : g_pat
            assign match_o[gp] = hit_pad[tail[gp]];
        end
    endgenerate

endmodule

// File: rtl/str_match_top.sv
module str_match_top
    import smt_pkg::*;
#(
    parameter int N_ENT = DEF_ENT,
    parameter int N_PAT = DEF_PAT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [CHAR_W-1:0]    in_char,
    input  logic                 pkt_start,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [IDX_W-1:0]     cfg_addr,
    input  logic [CHAR_W-1:0]    cfg_char,
    input  logic                 cfg_root,
    input  logic [IDX_W-1:0]     cfg_parent,
    output logic [N_PAT-1:0]     match_o
);

    entry_cfg_t [N_ENT-1:0]      ent;
    logic [N_PAT-1:0][IDX_W-1:0] tail;
    logic [N_ENT-1:0]            chain_q;
    logic [N_ENT-1:0]            hit;
    logic [N_ENT-1:0]            root_vec;
    logic [MAX_ENT-1:0]          prev_pad;
    logic [MAX_ENT-1:0]          hit_pad;
    cfg_kind_e                   cfg_kind;

    assign cfg_kind = cfg_kind_e'(cfg_sel);

    smt_cfg_store #(.N_ENT(N_ENT), .N_PAT(N_PAT)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_kind   (cfg_kind),
        .cfg_addr   (cfg_addr),
        .cfg_char   (cfg_char),
        .cfg_root   (cfg_root),
        .cfg_parent (cfg_parent),
        .ent_o      (ent),
        .tail_o     (tail)
    );

    // A packet start makes the current byte the first one: old chain is not seen.
    assign prev_pad = pkt_start ? '0 : MAX_ENT'(chain_q);

    generate
        for (genvar gi = 0; gi < N_ENT; gi++) begin : g_state
            smt_entry u_entry (
                .cfg      (ent[gi]),
                .in_valid (in_valid),
                .in_char  (in_char),
                .prev_pad (prev_pad),
                .hit      (hit[gi])
            );
            assign root_vec[gi] = ent[gi].root;
        end
    endgenerate

    smt_chain_reg #(.N_ENT(N_ENT)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .pkt_start (pkt_start),
        .hit       (hit),
        .chain_q   (chain_q)
    );

    assign hit_pad = MAX_ENT'(hit);

    smt_tail_sel #(.N_PAT(N_PAT)) u_tail (
        .hit_pad (hit_pad),
        .tail    (tail),
        .match_o (match_o)
    );

endmodule

// File: rtl/str_match_chk.sv
module str_match_chk #(
    parameter int N_ENT = 13,
    parameter int N_PAT = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              pkt_start,
    input logic [N_PAT-1:0]  match_o,
    input logic [N_ENT-1:0]  chain_q,
    input logic [N_ENT-1:0]  root_vec
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (chain_q == '0));

    // R5
    idle_no_match_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> (match_o == '0));

    // R5
    idle_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !pkt_start) |=> $stable(chain_q));

    // R6
    start_idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && !in_valid) |=> (chain_q == '0));

    // R6
    start_byte_roots_only_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && in_valid) |=> ((chain_q & ~$past(root_vec)) == '0));

endmodule

bind str_match_top str_match_chk #(.N_ENT(N_ENT), .N_PAT(N_PAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .pkt_start (pkt_start),
    .match_o   (match_o),
    .chain_q   (chain_q),
    .root_vec  (root_vec)
);

// File: tb/str_match_top_tb.sv
module str_match_top_tb;

    localparam int NP = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_char = 8'h00;
    logic       pkt_start = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic [7:0] cfg_char = 8'h00;
    logic       cfg_root = 1'b0;
    logic [5:0] cfg_parent = '0;
    logic [NP-1:0] match_o;

    int checks = 0;
    int errors = 0;

    string pats [NP] = '{"CF", "BCD", "BBA", "BA", "EBBC", "EBC"};
    logic [7:0] hist [8];
    int hlen = 0;

    always #10 clk = ~clk;

    str_match_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
        .pkt_start(pkt_start), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_char(cfg_char), .cfg_root(cfg_root),
        .cfg_parent(cfg_parent), .match_o(match_o)
    );

    task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: match_o actual %b expected %b", tag, act, exp);
        end
    endtask

    // Software substring model over bytes accepted since the last packet start.
    task automatic model_push(logic [7:0] c, logic v, logic s);
        if (s) hlen = 0;
        if (v) begin
            for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = c;
            if (hlen < 8) hlen++;
        end
    endtask

    function automatic logic [NP-1:0] ref_mask();
        logic [NP-1:0] m = '0;
        for (int p = 0; p < NP; p++) begin
            int len = pats[p].len();
            logic ok = (hlen >= len);
            for (int k = 0; k < len; k++)
                if (hist[len-1-k] != pats[p][k]) ok = 1'b0;
            m[p] = ok;
        end
        return m;
    endfunction

    // Drive at falling edge, judge the combinational flags mid-low phase.
    task automatic feed_exp(logic [7:0] c, logic v, logic s, logic [NP-1:0] exp, string tag);
        @(negedge clk);
        in_char = c; in_valid = v; pkt_start = s;
        model_push(c, v, s);
        #5;
        check(tag, match_o, exp);
    endtask

    task automatic feed(logic [7:0] c, logic v, logic s, string tag);
        logic [NP-1:0] e;
        @(negedge clk);
        in_char = c; in_valid = v; pkt_start = s;
        model_push(c, v, s);
        e = v ? ref_mask() : '0;
        #5;
        check(tag, match_o, e);
    endtask

    task automatic feed_str(string str, logic first_start, string tag);
        for (int k = 0; k < str.len(); k++)
            feed(str[k], 1'b1, (k == 0) && first_start, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; pkt_start = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0; pkt_start = 1'b0; rst = 1'b1;
        hlen = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(logic sel, logic [5:0] addr, logic [7:0] c, logic r, logic [5:0] par);
        @(negedge clk);
        in_valid = 1'b0; pkt_start = 1'b0;
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_char = c; cfg_root = r; cfg_parent = par;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); #5;
        check("R1 reset state", match_o, '0);
        feed("C", 1'b1, 1'b0, "R1 prefix before reset");
        do_reset();
        feed_exp("F", 1'b1, 1'b0, '0, "R1 no chain across reset");
    endtask

    task automatic t_root();
        feed_exp("B", 1'b1, 1'b1, '0, "R2 start byte");
        feed_exp("A", 1'b1, 1'b0, 6'b001000, "R2 BA from packet start");
        feed_str("XXBA", 1'b0, "R2 mid-stream start");
    endtask

    task automatic t_timing();
        feed_exp("B", 1'b1, 1'b1, '0, "R3 byte1");
        feed_exp("C", 1'b1, 1'b0, '0, "R3 byte2");
        feed_exp("D", 1'b1, 1'b0, 6'b000010, "R3 final byte");
        feed_exp("D", 1'b1, 1'b0, '0, "R3 one cycle only");
    endtask

    task automatic t_broken();
        feed_str("CXF", 1'b1, "R4 broken CF");
        feed_str("EBXC", 1'b1, "R4 broken EBC");
        feed_str("BCCD", 1'b1, "R4 broken BCD");
    endtask

    task automatic t_gap();
        feed_exp("C", 1'b1, 1'b1, '0, "R5 first");
        feed_exp("F", 1'b0, 1'b0, '0, "R5 idle with F on bus");
        feed_exp("F", 1'b0, 1'b0, '0, "R5 idle again");
        feed_exp("F", 1'b1, 1'b0, 6'b000001, "R5 CF across gap");
    endtask

    task automatic t_pkt_start();
        feed_exp("C", 1'b1, 1'b0, '0, "R6 prefix");
        feed_exp("F", 1'b1, 1'b1, '0, "R6 strobe with continuation");
        feed_exp("B", 1'b1, 1'b0, '0, "R6 prefix B");
        feed_exp("A", 1'b1, 1'b1, '0, "R6 strobe on non-start char");
        feed_exp("E", 1'b1, 1'b0, '0, "R6 prefix E");
        feed_exp("B", 1'b0, 1'b1, '0, "R6 idle strobe");
        feed_exp("C", 1'b1, 1'b0, '0, "R6 no EBC after idle strobe");
        feed_exp("F", 1'b1, 1'b0, 6'b000001, "R6 CF on fresh chain");
    endtask

    task automatic t_shared();
        feed_str("BBA", 1'b1, "R7 BBA and BA same byte");
        feed_str("EBBC", 1'b1, "R7 EBBC");
        feed_str("EBC", 1'b1, "R7 EBC sibling");
        feed_str("BBCD", 1'b1, "R7 BCD after B");
    endtask

    task automatic t_entry_write();
        cfg_write(1'b0, 6'd1, "G", 1'b0, 6'd0);
        feed_exp("C", 1'b1, 1'b1, '0, "R8 prefix");
        feed_exp("G", 1'b1, 1'b0, 6'b000001, "R8 rewritten CG");
        feed_exp("C", 1'b1, 1'b0, '0, "R8 prefix again");
        feed_exp("F", 1'b1, 1'b0, '0, "R8 old CF gone");
    endtask

    task automatic t_tail_write();
        cfg_write(1'b1, 6'd0, 8'h00, 1'b0, 6'd0);
        feed_exp("X", 1'b1, 1'b1, '0, "R9 filler");
        feed_exp("C", 1'b1, 1'b0, 6'b000001, "R9 flag on state 0");
    endtask

    task automatic t_restore();
        do_reset();
        feed_str("CF", 1'b1, "R10 default CF restored");
        feed_str("CG", 1'b1, "R10 CG no longer matches");
        feed_str("C", 1'b1, "R10 lone C no flag");
    endtask

    task automatic t_random();
        string alpha = "ABCDEF";
        hlen = 0;
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 8) begin
                feed(alpha[$urandom_range(0, 5)], 1'b0, r < 2, "R3 random idle");
            end else if (r < 14) begin
                string s = pats[$urandom_range(0, NP-1)];
                feed_str(s, 1'b0, "R7 random planted");
            end else begin
                feed(alpha[$urandom_range(0, 5)], 1'b1, r > 97, "R4 random byte");
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung run expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_root();
        t_timing();
        t_broken();
        t_gap();
        t_pkt_start();
        t_shared();
        t_random();
        t_entry_write();
        t_tail_write();
        t_restore();
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule